// File: doc/BRIEF.md
# Static Wear-Leveling Block Allocator

This block keeps the wear bookkeeping for a fixed pool of non-volatile memory blocks and decides where the next write lands. For every physical block it holds a 20-bit erase/write counter, an allocated flag and a retired flag. A client asks for a block with a one-cycle request. The allocator walks the table one block per clock and answers with the index of the free, healthy block that has the lowest counter. If no such block exists it answers with a no-block flag instead.

Clients report three kinds of event. A finished write bumps that block's counter. A released block goes back to the pool. Each write is followed by a verification read, and its result comes in together with the corrected-error status of that read. A block leaves service for good in two cases: its counter reaches the endurance limit, or a verification read reports that error correction fired. This way a worn block is removed based on its observed health as well as on its count.

A parallel monitor watches the wear spread across all blocks that are still in service. When the spread grows too wide, it asks for a migration. The migration takes the data in the least-worn allocated block and moves it into the least-worn free block. The data movement, the memory bus and saving the tables across power loss are handled elsewhere. The pool holds twice as many physical blocks as there are logical data streams.

Top module: `wl_alloc_top`

## Requirements
- R1: An allocation grants the block with the smallest counter among blocks that are neither allocated nor retired. On equal counters the lowest index wins. The granted block becomes allocated.
- R2: A request sampled at a rising edge while the allocator is idle gets its answer (`alloc_grant` or `alloc_none`) after exactly NUM_BLOCKS further rising edges. The answer is high for one cycle only. Requests arriving while a scan is in progress are ignored.
- R3: A write-done event adds one to the counter of the named block. The counter saturates at 2^20-1.
- R4: When a block's counter reaches ENDURANCE, the block is retired. A retired block is never granted again and is no longer allocated.
- R5: A verification result with `vfy_ecc_err` high retires the named block at once, whatever its count. A result with `vfy_ecc_err` low has no effect.
- R6: A free event clears the allocated flag of the named block, which makes it eligible for grants again.
- R7: When no block is both unallocated and unretired, the request is answered with `alloc_none` and no grant.
- R8: `mig_req` is high when three conditions hold over non-retired blocks: the highest counter minus the lowest counter exceeds GAP_LIMIT, at least one of them is allocated, and at least one is free. `mig_src` is the least-worn allocated block and `mig_dst` is the least-worn free block, with ties going to the lowest index. These outputs follow a table change by one cycle.
- R9: When `mig_ack` is high in a cycle where `mig_req` is high, the source block is freed and the destination block becomes allocated. `mig_req` is low in the following cycle, and the request is then evaluated again on the new table.
- R10: After reset all counters are zero, no block is allocated or retired, and `alloc_grant`, `alloc_none` and `mig_req` are low.
- R11: The pool holds NUM_BLOCKS = 2 × NUM_STREAMS blocks. With all of them healthy, exactly that many grants succeed before `alloc_none` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_req | input | 1 | One-cycle allocation request |
| alloc_grant | output | 1 | One-cycle grant strobe |
| alloc_none | output | 1 | One-cycle no-block-available strobe |
| alloc_idx | output | clog2(2·NUM_STREAMS) | Granted block index |
| free_vld | input | 1 | Release a block |
| free_idx | input | clog2(2·NUM_STREAMS) | Block to release |
| wr_done_vld | input | 1 | A write to a block finished |
| wr_done_idx | input | clog2(2·NUM_STREAMS) | Block that was written |
| vfy_vld | input | 1 | Verification read result valid |
| vfy_idx | input | clog2(2·NUM_STREAMS) | Block that was verified |
| vfy_ecc_err | input | 1 | Error correction fired on the verification read |
| mig_req | output | 1 | Migration requested |
| mig_src | output | clog2(2·NUM_STREAMS) | Least-worn allocated block to move data from |
| mig_dst | output | clog2(2·NUM_STREAMS) | Least-worn free block to move data into |
| mig_ack | input | 1 | Migration done; swap allocation of source and destination |

## Verification
Equal counters are targeted with grants from a freshly reset pool. A selector that compared with less-or-equal would hand out the highest index instead of the lowest. The spread threshold is tested at exactly GAP_LIMIT and at one above it. An off-by-one comparison would either raise the migration too early or miss it. Retirement is checked with a count one below the limit, which must still grant, and at the limit, which must not. The error-flag path is checked with both flag values, so a design that retired on any verification, or ignored the flag, would grant the wrong block. A second request issued mid-scan must produce no extra grant. After an acknowledge, `mig_req` must drop for a cycle. A design that kept it high would invite a double swap.

// File: rtl/wl_pkg.sv
package wl_pkg;

    // Wear counter width is fixed by the block's definition.
    localparam int CNT_W = 20;

    typedef logic [CNT_W-1:0] wear_cnt_t;

    // Per-block bookkeeping entry.
    typedef struct packed {
        wear_cnt_t cnt;
        logic      alloc;
        logic      retired;
    } blk_state_t;

    typedef enum logic [0:0] {
        SC_IDLE = 1'b0,
        SC_SCAN = 1'b1
    } scan_state_e;

endpackage

// File: rtl/wl_block_table.sv
module wl_block_table
    import wl_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int IDX_W      = 3,
    parameter int ENDURANCE  = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_vld,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             free_vld,
    input  logic [IDX_W-1:0] free_idx,
    input  logic             wr_vld,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             vfy_vld,
    input  logic [IDX_W-1:0] vfy_idx,
    input  logic             vfy_err,
    input  logic             swap_vld,
    input  logic [IDX_W-1:0] swap_src,
    input  logic [IDX_W-1:0] swap_dst,
    output blk_state_t       state_o [NUM_BLOCKS]
);

    localparam wear_cnt_t END_CNT = wear_cnt_t'(ENDURANCE);
    localparam wear_cnt_t CNT_MAX = '1;

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(b);

        blk_state_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            // R3: saturating wear count
            if (wr_vld && wr_idx == MY_IDX && st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            // R6: release
            if (free_vld && free_idx == MY_IDX) begin
                st_d.alloc = 1'b0;
            end
            // R9: migration swap
            if (swap_vld && swap_src == MY_IDX) begin
                st_d.alloc = 1'b0;
            end
            if (swap_vld && swap_dst == MY_IDX) begin
                st_d.alloc = 1'b1;
            end
            // R1: grant claims the block
            if (set_vld && set_idx == MY_IDX) begin
                st_d.alloc = 1'b1;
            end
            // R4: endurance limit
            if (st_d.cnt >= END_CNT) begin
                st_d.retired = 1'b1;
            end
            // R5: corrected error seen on verification read
            if (vfy_vld && vfy_err && vfy_idx == MY_IDX) begin
                st_d.retired = 1'b1;
            end
            // a retired block holds no data stream
            if (st_d.retired) begin
                st_d.alloc = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign state_o[b] = st_q;
    end

endmodule

// File: rtl/wl_min_scan.sv
module wl_min_scan
    import wl_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int IDX_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  blk_state_t       state_i [NUM_BLOCKS],
    output logic             grant_o,
    output logic             none_o,
    output logic [IDX_W-1:0] gidx_o,
    output logic             set_vld_o,
    output logic [IDX_W-1:0] set_idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);

    typedef struct packed {
        scan_state_e      state;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] best_idx;
        wear_cnt_t        best_cnt;
        logic             found;
        logic             grant;
        logic             none;
        logic [IDX_W-1:0] gidx;
    } scan_t;

    scan_t s_d, s_q;

    blk_state_t       cur;
    blk_state_t       fin;
    logic             take;
    logic             n_found;
    logic [IDX_W-1:0] n_idx;
    wear_cnt_t        n_cnt;
    logic             ok;

    always_comb begin
        s_d       = s_q;
        s_d.grant = 1'b0;
        s_d.none  = 1'b0;
        set_vld_o = 1'b0;
        set_idx_o = s_q.best_idx;
        cur       = state_i[s_q.idx];
        take      = !cur.alloc && !cur.retired && (!s_q.found || cur.cnt < s_q.best_cnt);
        n_found   = s_q.found | take;
        n_idx     = take ? s_q.idx : s_q.best_idx;
        n_cnt     = take ? cur.cnt : s_q.best_cnt;
        fin       = state_i[n_idx];
        ok        = n_found && !fin.alloc && !fin.retired;

        unique case (s_q.state)
            SC_IDLE: begin
                // R2: requests are only taken while idle
                if (req_i) begin
                    s_d.state    = SC_SCAN;
                    s_d.idx      = '0;
                    s_d.found    = 1'b0;
                    s_d.best_idx = '0;
                    s_d.best_cnt = '1;
                end
            end
            SC_SCAN: begin
                s_d.found    = n_found;
                s_d.best_idx = n_idx;
                s_d.best_cnt = n_cnt;
                if (s_q.idx == LAST_IDX) begin
                    s_d.state = SC_IDLE;
                    s_d.grant = ok;
                    s_d.none  = !ok;
                    s_d.gidx  = n_idx;
                    set_vld_o = ok;
                    set_idx_o = n_idx;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: s_d.state = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: SC_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_o = s_q.grant;
    assign none_o  = s_q.none;
    assign gidx_o  = s_q.gidx;

endmodule

// File: rtl/wl_gap_monitor.sv
module wl_gap_monitor
    import wl_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int IDX_W      = 3,
    parameter int GAP_LIMIT  = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  blk_state_t       state_i [NUM_BLOCKS],
    input  logic             ack_i,
    output logic             mig_req_o,
    output logic [IDX_W-1:0] mig_src_o,
    output logic [IDX_W-1:0] mig_dst_o
);

    localparam wear_cnt_t GAP_CNT = wear_cnt_t'(GAP_LIMIT);

    typedef struct packed {
        logic             req;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
    } mig_t;

    mig_t m_d, m_q;

    wear_cnt_t        hi_cnt, lo_cnt, src_cnt, dst_cnt;
    logic             have_live, have_src, have_dst;
    logic [IDX_W-1:0] src_idx, dst_idx;

    always_comb begin
        hi_cnt    = '0;
        lo_cnt    = '1;
        src_cnt   = '1;
        dst_cnt   = '1;
        have_live = 1'b0;
        have_src  = 1'b0;
        have_dst  = 1'b0;
        src_idx   = '0;
        dst_idx   = '0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (!state_i[i].retired) begin
                have_live = 1'b1;
                if (state_i[i].cnt > hi_cnt) hi_cnt = state_i[i].cnt;
                if (state_i[i].cnt < lo_cnt) lo_cnt = state_i[i].cnt;
                // strict compare keeps the lowest index on ties
                if (state_i[i].alloc) begin
                    if (!have_src || state_i[i].cnt < src_cnt) begin
                        src_cnt = state_i[i].cnt;
                        src_idx = IDX_W'(i);
                    end
                    have_src = 1'b1;
                end else begin
                    if (!have_dst || state_i[i].cnt < dst_cnt) begin
                        dst_cnt = state_i[i].cnt;
                        dst_idx = IDX_W'(i);
                    end
                    have_dst = 1'b1;
                end
            end
        end

        m_d.src = src_idx;
        m_d.dst = dst_idx;
        // R8 spread check, R9 one quiet cycle after an accepted ack
        m_d.req = have_live && have_src && have_dst
                  && ((hi_cnt - lo_cnt) > GAP_CNT)
                  && !(m_q.req && ack_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign mig_req_o = m_q.req;
    assign mig_src_o = m_q.src;
    assign mig_dst_o = m_q.dst;

endmodule

// File: rtl/wl_alloc_top.sv
module wl_alloc_top
    import wl_pkg::*;
#(
    parameter int NUM_STREAMS = 4,
    parameter int ENDURANCE   = 1000000,
    parameter int GAP_LIMIT   = 4096
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               alloc_req,
    output logic                               alloc_grant,
    output logic                               alloc_none,
    output logic [$clog2(2*NUM_STREAMS)-1:0]   alloc_idx,
    input  logic                               free_vld,
    input  logic [$clog2(2*NUM_STREAMS)-1:0]   free_idx,
    input  logic                               wr_done_vld,
    input  logic [$clog2(2*NUM_STREAMS)-1:0]   wr_done_idx,
    input  logic                               vfy_vld,
    input  logic [$clog2(2*NUM_STREAMS)-1:0]   vfy_idx,
    input  logic                               vfy_ecc_err,
    output logic                               mig_req,
    output logic [$clog2(2*NUM_STREAMS)-1:0]   mig_src,
    output logic [$clog2(2*NUM_STREAMS)-1:0]   mig_dst,
    input  logic                               mig_ack
);

    // R11: two physical blocks per logical stream
    localparam int NUM_BLOCKS = 2 * NUM_STREAMS;
    localparam int IDX_W      = $clog2(NUM_BLOCKS);

    blk_state_t       blk_state [NUM_BLOCKS];
    logic             set_vld;
    logic [IDX_W-1:0] set_idx;
    logic             swap_vld;
    logic [NUM_BLOCKS-1:0] alloc_vec;
    logic [NUM_BLOCKS-1:0] retired_vec;

    assign swap_vld = mig_req && mig_ack;

    wl_block_table #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .IDX_W      (IDX_W),
        .ENDURANCE  (ENDURANCE)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vld  (set_vld),
        .set_idx  (set_idx),
        .free_vld (free_vld),
        .free_idx (free_idx),
        .wr_vld   (wr_done_vld),
        .wr_idx   (wr_done_idx),
        .vfy_vld  (vfy_vld),
        .vfy_idx  (vfy_idx),
        .vfy_err  (vfy_ecc_err),
        .swap_vld (swap_vld),
        .swap_src (mig_src),
        .swap_dst (mig_dst),
        .state_o  (blk_state)
    );

    wl_min_scan #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .IDX_W      (IDX_W)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (alloc_req),
        .state_i   (blk_state),
        .grant_o   (alloc_grant),
        .none_o    (alloc_none),
        .gidx_o    (alloc_idx),
        .set_vld_o (set_vld),
        .set_idx_o (set_idx)
    );

    wl_gap_monitor #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .IDX_W      (IDX_W),
        .GAP_LIMIT  (GAP_LIMIT)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (blk_state),
        .ack_i     (mig_ack),
        .mig_req_o (mig_req),
        .mig_src_o (mig_src),
        .mig_dst_o (mig_dst)
    );

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_vec
        assign alloc_vec[b]   = blk_state[b].alloc;
        assign retired_vec[b] = blk_state[b].retired;
    end

endmodule

// File: rtl/wl_alloc_checker.sv
module wl_alloc_checker #(
    parameter int NUM_BLOCKS = 8,
    parameter int IDX_W      = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  alloc_grant,
    input logic                  alloc_none,
    input logic [IDX_W-1:0]      alloc_idx,
    input logic                  mig_req,
    input logic                  mig_ack,
    input logic [IDX_W-1:0]      mig_src,
    input logic [IDX_W-1:0]      mig_dst,
    input logic [NUM_BLOCKS-1:0] alloc_vec,
    input logic [NUM_BLOCKS-1:0] retired_vec
);

    AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |=> !alloc_grant); // R2

    AST_NONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_none |=> !alloc_none); // R7

    AST_GRANT_XOR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |-> !alloc_none); // R7

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |-> (alloc_vec[alloc_idx] && !retired_vec[alloc_idx])); // R1

    AST_RETIRE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (retired_vec & $past(retired_vec)) == $past(retired_vec)); // R4

    AST_MIG_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        mig_req |-> (mig_src != mig_dst)); // R8

    AST_MIG_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mig_req && mig_ack) |=> !mig_req); // R9

endmodule

bind wl_alloc_top wl_alloc_checker #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .IDX_W      (IDX_W)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_grant (alloc_grant),
    .alloc_none  (alloc_none),
    .alloc_idx   (alloc_idx),
    .mig_req     (mig_req),
    .mig_ack     (mig_ack),
    .mig_src     (mig_src),
    .mig_dst     (mig_dst),
    .alloc_vec   (alloc_vec),
    .retired_vec (retired_vec)
);

// File: tb/test_wl_alloc_top.sv
module test_wl_alloc_top;

    localparam int NS   = 4;
    localparam int NB   = 2 * NS;
    localparam int IW   = $clog2(NB);
    localparam int ENDU = 8;
    localparam int GAP  = 4;

    localparam logic [1:0] OP_ALLOC = 2'd0;
    localparam logic [1:0] OP_WR    = 2'd1;
    localparam logic [1:0] OP_FREE  = 2'd2;
    localparam logic [1:0] OP_VFY   = 2'd3;

    typedef struct packed {
        logic [1:0]    op;
        logic [IW-1:0] idx;
        logic          err;
        logic          exp_none;
        logic [IW-1:0] exp_idx;
    } vec_t;

    // Vectors walk a pool that starts fresh from reset.
    localparam vec_t VEC [14] = '{
        '{OP_ALLOC, 3'd0, 1'b0, 1'b0, 3'd0}, // R1 tie -> lowest
        '{OP_ALLOC, 3'd0, 1'b0, 1'b0, 3'd1}, // R1
        '{OP_WR,    3'd2, 1'b0, 1'b0, 3'd0}, // R3
        '{OP_FREE,  3'd0, 1'b0, 1'b0, 3'd0}, // R6
        '{OP_ALLOC, 3'd0, 1'b0, 1'b0, 3'd0}, // R6 freed block back
        '{OP_WR,    3'd3, 1'b0, 1'b0, 3'd0}, // R3
        '{OP_WR,    3'd0, 1'b0, 1'b0, 3'd0}, // R3
        '{OP_FREE,  3'd0, 1'b0, 1'b0, 3'd0}, // R6
        '{OP_ALLOC, 3'd0, 1'b0, 1'b0, 3'd4}, // R3 worn 0,2,3 skipped
        '{OP_VFY,   3'd5, 1'b1, 1'b0, 3'd0}, // R5 retire on error
        '{OP_ALLOC, 3'd0, 1'b0, 1'b0, 3'd6}, // R5 block 5 skipped
        '{OP_VFY,   3'd7, 1'b0, 1'b0, 3'd0}, // R5 clean read no effect
        '{OP_ALLOC, 3'd0, 1'b0, 1'b0, 3'd7}, // R5
        '{OP_ALLOC, 3'd0, 1'b0, 1'b0, 3'd0}  // R1
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_req = 1'b0;
    logic          alloc_grant, alloc_none;
    logic [IW-1:0] alloc_idx;
    logic          free_vld = 1'b0;
    logic [IW-1:0] free_idx = '0;
    logic          wr_done_vld = 1'b0;
    logic [IW-1:0] wr_done_idx = '0;
    logic          vfy_vld = 1'b0;
    logic [IW-1:0] vfy_idx = '0;
    logic          vfy_ecc_err = 1'b0;
    logic          mig_req;
    logic [IW-1:0] mig_src, mig_dst;
    logic          mig_ack = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wl_alloc_top #(
        .NUM_STREAMS (NS),
        .ENDURANCE   (ENDU),
        .GAP_LIMIT   (GAP)
    ) i_wl_alloc_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_req   (alloc_req),
        .alloc_grant (alloc_grant),
        .alloc_none  (alloc_none),
        .alloc_idx   (alloc_idx),
        .free_vld    (free_vld),
        .free_idx    (free_idx),
        .wr_done_vld (wr_done_vld),
        .wr_done_idx (wr_done_idx),
        .vfy_vld     (vfy_vld),
        .vfy_idx     (vfy_idx),
        .vfy_ecc_err (vfy_ecc_err),
        .mig_req     (mig_req),
        .mig_src     (mig_src),
        .mig_dst     (mig_dst),
        .mig_ack     (mig_ack)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One-cycle event strobe, then one more cycle so registered migration outputs settle.
    task automatic do_op(input logic [1:0] op, input int idx, input bit err);
        @(negedge clk);
        case (op)
            OP_WR:   begin wr_done_vld = 1'b1; wr_done_idx = IW'(idx); end
            OP_FREE: begin free_vld = 1'b1; free_idx = IW'(idx); end
            OP_VFY:  begin vfy_vld = 1'b1; vfy_idx = IW'(idx); vfy_ecc_err = err; end
            default: ;
        endcase
        @(negedge clk);
        wr_done_vld = 1'b0;
        free_vld    = 1'b0;
        vfy_vld     = 1'b0;
        vfy_ecc_err = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_alloc(input string tag, input bit exp_none, input int exp_idx);
        int lat;
        @(negedge clk);
        alloc_req = 1'b1;
        @(negedge clk);
        alloc_req = 1'b0;
        lat = 0;
        while (!alloc_grant && !alloc_none && lat < NB + 4) begin
            @(negedge clk);
            lat++;
        end
        check_eq({tag, " R2 latency"}, lat, NB);
        check_eq({tag, " R7 none flag"}, int'(alloc_none), int'(exp_none));
        check_eq({tag, " R1 grant flag"}, int'(alloc_grant), int'(!exp_none));
        if (!exp_none) check_eq({tag, " R1 index"}, int'(alloc_idx), exp_idx);
        @(negedge clk);
        check_eq({tag, " R2 one-cycle strobe"}, int'(alloc_grant | alloc_none), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R2: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        // R10 reset state
        repeat (2) @(negedge clk);
        check_eq("R10 grant in reset", int'(alloc_grant), 0);
        check_eq("R10 none in reset", int'(alloc_none), 0);
        check_eq("R10 mig in reset", int'(mig_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk
        for (int v = 0; v < 14; v++) begin
            if (VEC[v].op == OP_ALLOC) begin
                do_alloc($sformatf("vec%0d", v), VEC[v].exp_none, int'(VEC[v].exp_idx));
            end else begin
                do_op(VEC[v].op, int'(VEC[v].idx), VEC[v].err);
            end
        end
        check_eq("R8 small spread no mig", int'(mig_req), 0);

        // R2 request during scan is ignored
        do_reset();
        @(negedge clk);
        alloc_req = 1'b1;
        @(negedge clk);
        alloc_req = 1'b0;
        repeat (2) @(negedge clk);
        alloc_req = 1'b1;
        @(negedge clk);
        alloc_req = 1'b0;
        begin
            int grants;
            grants = 0;
            for (int c = 0; c < 3 * NB; c++) begin
                if (alloc_grant) grants++;
                @(negedge clk);
            end
            check_eq("R2 busy request ignored", grants, 1);
        end

        // R11 pool size and R7 exhaustion
        do_reset();
        for (int k = 0; k < NB; k++) do_alloc($sformatf("R11 fill%0d", k), 1'b0, k);
        do_alloc("R7 exhausted", 1'b1, 0);

        // R4 endurance: one below limit still usable, limit retires
        do_op(OP_FREE, 0, 1'b0);
        for (int k = 0; k < ENDU - 1; k++) do_op(OP_WR, 0, 1'b0);
        do_alloc("R4 below limit", 1'b0, 0);
        do_op(OP_FREE, 0, 1'b0);
        do_op(OP_WR, 0, 1'b0);
        do_alloc("R4 at limit", 1'b1, 0);
        check_eq("R4 retired leaves spread", int'(mig_req), 0);

        // R8 spread threshold and R9 acknowledge
        do_reset();
        do_alloc("R8 setup", 1'b0, 0);
        for (int k = 0; k < GAP; k++) do_op(OP_WR, 1, 1'b0);
        check_eq("R8 spread equal limit", int'(mig_req), 0);
        do_op(OP_WR, 1, 1'b0);
        check_eq("R8 spread over limit", int'(mig_req), 1);
        check_eq("R8 source", int'(mig_src), 0);
        check_eq("R8 destination", int'(mig_dst), 2);
        @(negedge clk);
        mig_ack = 1'b1;
        @(negedge clk);
        mig_ack = 1'b0;
        check_eq("R9 req drops after ack", int'(mig_req), 0);
        @(negedge clk);
        check_eq("R9 req re-evaluated", int'(mig_req), 1);
        check_eq("R9 source after swap", int'(mig_src), 2);
        check_eq("R9 destination after swap", int'(mig_dst), 0);
        do_alloc("R9 freed source grantable", 1'b0, 0);
        @(negedge clk);
        check_eq("R8 tie source", int'(mig_src), 0);
        check_eq("R8 tie destination", int'(mig_dst), 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule